// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat cache-line burst in a synchronous burst memory. When an access starts, it captures the full starting address and the burst order. From then on it steps the two low address bits through the chosen order, one position for each cycle in which the active-low advance strobe is asserted. The bits above the burst field stay fixed until the next access starts.

Two orders are available. Linear order counts upward from the starting position and wraps inside the aligned group of four. Interleaved order combines the starting position with a beat count by bitwise XOR. The order select is sampled only on the edge that starts an access, so a burst keeps its order to the end. A start request wins over an advance in the same cycle. Advancing past the last beat wraps back to the starting address, and the sequence then repeats.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no start request, `addr_o` is zero.
- R2: After a rising edge with `ld_i`=1, `addr_o` equals the `start_addr_i` value sampled at that edge.
- R3: After a rising edge with `ld_i`=0 and `adv_n_i`=1, `addr_o` keeps its previous value.
- R4: Bits of `addr_o` above the burst field (bits ADDR_W-1 down to LOW_W) change only on an edge with `ld_i`=1.
- R5: With `order_sel_i`=0 sampled at the start, the low LOW_W bits after k advances equal (start + k) mod 4. For example, a start of 2 gives 2,3,0,1.
- R6: With `order_sel_i`=1 sampled at the start, the low LOW_W bits after k advances equal start XOR (k mod 4). For example, a start of 1 gives 1,0,3,2.
- R7: `order_sel_i` is sampled only on an edge with `ld_i`=1. A change on any other edge has no effect on the sequence of the running burst.
- R8: On an edge with both `ld_i`=1 and `adv_n_i`=0, the start request wins. `addr_o` shows the new start address, and the next advance moves it to the second beat.
- R9: The fourth advance of a burst returns `addr_o` to the starting address, and further advances repeat the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | Start request; captures the address and order |
| start_addr_i | input | ADDR_W | Starting address of the burst |
| adv_n_i | input | 1 | Advance strobe, active low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench builds the block with ADDR_W=12 and LOW_W=2. A 12-bit address is narrow enough that the upper field in its burst starts covers an arbitrary pattern, while the burst field keeps its real four-beat width. Every starting position is run in both orders through more than four advances, so each wrap point and each XOR pattern is exercised. Hold cycles are mixed in between advances. The bench also covers a start request that coincides with an advance and a change of the order select in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_STEP = 2'd1,
    CMD_LOAD = 2'd2
  } cmd_e;

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic ld_i,
  input  logic adv_n_i,
  output cmd_e cmd_o
);

  // A start request outranks an advance in the same cycle.
  always_comb begin
    if (ld_i)          cmd_o = CMD_LOAD;
    else if (!adv_n_i) cmd_o = CMD_STEP;
    else               cmd_o = CMD_HOLD;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd_i,
  output logic [LOW_W-1:0] beat_o,
  output logic             last_o
);

  localparam logic [LOW_W-1:0] LastBeat = {LOW_W{1'b1}};

  function automatic logic [LOW_W-1:0] beat_inc(input logic [LOW_W-1:0] b);
    return b + LOW_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_o <= '0;
    end else begin
      unique case (cmd_i)
        CMD_LOAD: beat_o <= '0;
        CMD_STEP: beat_o <= beat_inc(beat_o);
        default:  beat_o <= beat_o;
      endcase
    end
  end

  assign last_o = (beat_o == LastBeat);

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-LOW_W-1:0] hi_o,
  output logic [LOW_W-1:0]  start_lo_o,
  output order_e            order_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_o       <= '0;
      start_lo_o <= '0;
      order_o    <= ORD_LINEAR;
    end else if (cmd_i == CMD_LOAD) begin
      hi_o       <= start_addr_i[ADDR_W-1:LOW_W];
      start_lo_o <= start_addr_i[LOW_W-1:0];
      order_o    <= order_e'(order_sel_i);
    end
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int LOW_W = 2
) (
  input  logic [LOW_W-1:0] start_lo_i,
  input  logic [LOW_W-1:0] beat_i,
  input  order_e           order_i,
  output logic [LOW_W-1:0] lo_o
);

  logic [LOW_W-1:0] lin_pos;
  logic [LOW_W-1:0] xor_pos;

  function automatic logic [LOW_W-1:0] lin_map(input logic [LOW_W-1:0] s,
                                               input logic [LOW_W-1:0] b);
    return s + b;
  endfunction

  assign lin_pos = lin_map(start_lo_i, beat_i);

  genvar gi;
  generate
    for (gi = 0; gi < LOW_W; gi++) begin : g_xor
      assign xor_pos[gi] = start_lo_i[gi] ^ beat_i[gi];
    end
  endgenerate

  assign lo_o = (order_i == ORD_XOR) ? xor_pos : lin_pos;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LOW_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_n_i,
  input  logic              order_sel_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int HiW = ADDR_W - LOW_W;

  cmd_e             cmd;
  logic [HiW-1:0]   hi;
  logic [LOW_W-1:0] start_lo;
  logic [LOW_W-1:0] beat;
  logic [LOW_W-1:0] lo;
  logic             last_beat;
  order_e           order_q;

  // Named events for the checker
  logic load_evt;
  logic step_evt;
  logic wrap_evt;

  burst_ctrl u_ctrl (
    .ld_i    (ld_i),
    .adv_n_i (adv_n_i),
    .cmd_o   (cmd)
  );

  burst_base_reg #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_base (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd),
    .start_addr_i (start_addr_i),
    .order_sel_i  (order_sel_i),
    .hi_o         (hi),
    .start_lo_o   (start_lo),
    .order_o      (order_q)
  );

  burst_beat_ctr #(.LOW_W(LOW_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd),
    .beat_o (beat),
    .last_o (last_beat)
  );

  burst_order_map #(.LOW_W(LOW_W)) u_map (
    .start_lo_i (start_lo),
    .beat_i     (beat),
    .order_i    (order_q),
    .lo_o       (lo)
  );

  assign load_evt = (cmd == CMD_LOAD);
  assign step_evt = (cmd == CMD_STEP);
  assign wrap_evt = step_evt && last_beat;

  assign addr_o = {hi, lo};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 18,
  parameter int LOW_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_i,
  input logic              adv_n_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              load_evt,
  input logic              step_evt,
  input logic              wrap_evt,
  input logic [LOW_W-1:0]  start_lo,
  input logic [LOW_W-1:0]  beat,
  input logic              order_q
);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> addr_o == $past(start_addr_i));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && adv_n_i) |=> $stable(addr_o));

  // R4
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(addr_o[ADDR_W-1:LOW_W]));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !order_q) |=>
      addr_o[LOW_W-1:0] == LOW_W'($past(addr_o[LOW_W-1:0]) + LOW_W'(1)));

  // R6
  xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order_q) |=>
      (addr_o[LOW_W-1:0] ^ start_lo) == LOW_W'($past(beat) + LOW_W'(1)));

  // R7
  order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(order_q));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !adv_n_i) |=> beat == '0);

  // R9
  wrap_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> addr_o[LOW_W-1:0] == start_lo);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ld_i         (ld_i),
  .adv_n_i      (adv_n_i),
  .start_addr_i (start_addr_i),
  .addr_o       (addr_o),
  .load_evt     (load_evt),
  .step_evt     (step_evt),
  .wrap_evt     (wrap_evt),
  .start_lo     (start_lo),
  .beat         (beat),
  .order_q      (order_q)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

  localparam int AW = 12;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          adv_n_i = 1'b1;
  logic          order_sel_i = 1'b0;
  logic [AW-1:0] addr_o;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .LOW_W(LW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_i         (ld_i),
    .start_addr_i (start_addr_i),
    .adv_n_i      (adv_n_i),
    .order_sel_i  (order_sel_i),
    .addr_o       (addr_o)
  );

  typedef struct {
    logic [AW-1:0] exp;
    int            due;
    string         tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    done     = 0;

  // Reference model state
  logic [AW-LW-1:0] m_hi = '0;
  int               m_start = 0;
  int               m_beat = 0;
  bit               m_xor = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [AW-1:0] model_addr();
    int lo;
    if (m_xor) lo = m_start ^ m_beat;
    else       lo = (m_start + m_beat) % 4;
    return {m_hi, LW'(lo)};
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input bit ld, input logic [AW-1:0] a, input bit adv_n,
                       input bit sel, input string tag);
    item_t it;
    @(negedge clk);
    ld_i = ld; start_addr_i = a; adv_n_i = adv_n; order_sel_i = sel;
    if (ld) begin
      m_hi = a[AW-1:LW]; m_start = int'(a[LW-1:0]); m_beat = 0; m_xor = sel;
    end else if (!adv_n) begin
      m_beat = (m_beat + 1) % 4;
    end
    it.exp = model_addr(); it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares results once they are due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_checks++;
      if (addr_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s: addr_o=%h expected=%h", it.tag, addr_o, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run incomplete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_checks++;
    if (addr_o !== '0) begin
      n_fail++;
      $display("FAIL R1: addr_o=%h expected=%h during reset", addr_o, {AW{1'b0}});
    end
    rst_n = 1'b1;
    drive(0, '0, 1, 0, "R1 after release");
    drive(0, '0, 1, 0, "R1 after release");

    // R2, R5, R9: linear from start 2, past the wrap
    drive(1, 12'h5A6, 1, 0, "R2 load");
    for (int k = 0; k < 6; k++) drive(0, 12'hFFF, 0, 0, "R5 R4 R9 linear step");
    // R3: hold with advance deasserted and address bus moving
    drive(0, 12'h0F0, 1, 1, "R3 hold");
    drive(0, 12'h333, 1, 0, "R3 hold");

    // R6: interleaved from start 1 and start 2
    drive(1, 12'hC31, 1, 1, "R2 load xor");
    for (int k = 0; k < 5; k++) drive(0, 12'h000, 0, 0, "R6 R9 xor step");
    drive(1, 12'h7E2, 1, 1, "R2 load xor");
    for (int k = 0; k < 4; k++) drive(0, 12'h000, 0, 1, "R6 xor step");

    // R8: start request with advance asserted
    drive(1, 12'h247, 0, 0, "R8 load over advance");
    drive(0, 12'h000, 0, 0, "R8 next beat");
    drive(1, 12'h9A1, 0, 1, "R8 load over advance");
    drive(0, 12'h000, 0, 0, "R8 next beat");

    // R7: order select changes mid-burst
    drive(1, 12'h3B3, 1, 0, "R7 load linear");
    drive(0, 12'h000, 0, 1, "R7 sel ignored");
    drive(0, 12'h000, 0, 1, "R7 sel ignored");
    drive(1, 12'h3B3, 1, 1, "R7 load xor");
    drive(0, 12'h000, 0, 0, "R7 sel ignored");
    drive(0, 12'h000, 0, 0, "R7 sel ignored");

    // All starts, both orders, with holds interleaved
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        drive(1, AW'((s * 37 + m * 1000) * 4 + s), 1, m[0], "R2 sweep load");
        for (int k = 0; k < 9; k++)
          drive(0, AW'(k * 91), (k % 3 == 2), ~m[0],
                m ? "R6 R3 sweep" : "R5 R3 sweep");
      end
    end

    drive(0, '0, 1, 0, "R3 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule